// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds or subtracts two floating-point operands in four clocked segments. Each operand has a sign bit, a biased exponent and a mantissa that is a pure fraction. A normalized mantissa has its most significant bit set, so it reads as 0.1xxx. A mantissa of all zeros stands for zero. The four segments are: pick the larger exponent, align the smaller operand, add or subtract the signed mantissas, and normalize. A register follows each segment and one clock drives them all, so a new operand pair can enter on every cycle.

An operand pair and the `op_sub` flag are presented with `in_valid`. The pair is taken on a rising edge when `in_ready` is high. The result appears on the output registers four edges later, marked by `out_valid`. Raising `stall` freezes every register at once, and each operation in flight resumes unchanged when `stall` drops. A per-result range flag reports an exponent that overflowed or underflowed during normalization. Rounding, special values and denormal operands are not handled: dropped alignment bits are truncated.

Top module: `fp_pipe_adder`

## Requirements
- R1: The result starts from the larger of the two biased exponents, whichever operand holds it; the operand with the smaller exponent is the one that is aligned.
- R2: The mantissa with the smaller exponent is shifted right by the exponent difference, and bits shifted past the LSB are dropped. A difference of MAN_W or more makes that mantissa zero.
- R3: With `op_sub`=1 the sign of B is inverted before the operation. Operands of equal sign are added. Operands of unlike sign have the smaller magnitude subtracted from the larger, and the result takes the sign of the larger (A wins a tie).
- R4: A sum that carries out of the fraction is shifted right by one and its exponent is incremented.
- R5: A nonzero result with k leading zero bits is shifted left by k and its exponent is reduced by k. Every nonzero result has its mantissa MSB set.
- R6: A zero mantissa result is output with sign 0, exponent 0 and range flag 0.
- R7: `out_range`=1 marks a bad exponent for that one result. If a carry occurs at exponent all-ones, the exponent stays all-ones. If k leading zeros meet an exponent of k or less, the exponent becomes 0. In both cases the normalized mantissa and the sign are kept.
- R8: A pair taken on one edge appears with `out_valid`=1 after exactly four rising edges, counting the edge that takes it. Back-to-back pairs produce back-to-back results, so n operations finish in n+3 cycles after the first is taken.
- R9: While `stall`=1, `in_ready` is 0, no input is taken, and all outputs hold their values. When `stall` drops, operations in flight continue unchanged.
- R10: During reset (`rst_n`=0), `out_valid` is 0 and no result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all segments |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| stall | input | 1 | Freezes the whole pipeline while high |
| in_valid | input | 1 | Operand pair on the inputs is meaningful |
| in_ready | output | 1 | High when a pair can be taken (not stalled) |
| op_sub | input | 1 | 1 computes A-B, 0 computes A+B |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_exp | input | EXP_W | Biased exponent of A |
| a_man | input | MAN_W | Fraction mantissa of A |
| b_sign | input | 1 | Sign of B |
| b_exp | input | EXP_W | Biased exponent of B |
| b_man | input | MAN_W | Fraction mantissa of B |
| out_valid | output | 1 | Result on the outputs is meaningful |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result biased exponent |
| out_man | output | MAN_W | Normalized result mantissa |
| out_range | output | 1 | Exponent overflow or underflow for this result |

## Verification
A stall and a new request can land in the same cycle. The bench raises `stall` while `in_valid` is high with a different operand pair, and an older operation sits halfway down the pipe. It then checks that `in_ready` is low, that no result appears early, and that the older result comes out intact once `stall` drops. It also checks that the request presented during the stall never produces a result. In a second case, a stall arrives while a finished result is on the outputs, and the bench checks that the result stays put over several cycles.

// File: rtl/fp_pipe_adder.sv
module fp_pipe_adder #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             out_valid,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man,
  output logic             out_range
);

  localparam int SH_W = $clog2(MAN_W + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] SH_SAT  = EXP_W'(MAN_W);

  function automatic logic [SH_W-1:0] lead_zeros(input logic [MAN_W-1:0] v);
    lead_zeros = SH_W'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (v[i]) lead_zeros = SH_W'(MAN_W - 1 - i);
  endfunction

  wire advance = !stall;
  assign in_ready = advance;

  // segment 1: exponent compare
  wire             b_sg_eff = b_sign ^ op_sub;
  wire             b_big    = b_exp > a_exp;
  wire [EXP_W-1:0] exp_diff = b_big ? b_exp - a_exp : a_exp - b_exp;

  logic             s1_v, s1_bsg, s1_ssg;
  logic [EXP_W-1:0] s1_exp;
  logic [MAN_W-1:0] s1_bman, s1_sman;
  logic [SH_W-1:0]  s1_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else if (advance) s1_v <= in_valid;

  always_ff @(posedge clk)
    if (advance) begin
      s1_exp  <= b_big ? b_exp : a_exp;
      s1_bsg  <= b_big ? b_sg_eff : a_sign;
      s1_bman <= b_big ? b_man : a_man;
      s1_ssg  <= b_big ? a_sign : b_sg_eff;
      s1_sman <= b_big ? a_man : b_man;
      s1_sh   <= (exp_diff >= SH_SAT) ? SH_W'(MAN_W) : exp_diff[SH_W-1:0];
    end

  // segment 2: alignment
  logic             s2_v, s2_bsg, s2_ssg;
  logic [EXP_W-1:0] s2_exp;
  logic [MAN_W-1:0] s2_bman, s2_sman;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s2_v <= 1'b0;
    else if (advance) s2_v <= s1_v;

  always_ff @(posedge clk)
    if (advance) begin
      s2_exp  <= s1_exp;
      s2_bsg  <= s1_bsg;
      s2_bman <= s1_bman;
      s2_ssg  <= s1_ssg;
      s2_sman <= s1_sman >> s1_sh;
    end

  // segment 3: signed add / subtract
  wire           same_sg = s2_bsg == s2_ssg;
  wire           big_ge  = s2_bman >= s2_sman;
  wire [MAN_W:0] ext_b   = {1'b0, s2_bman};
  wire [MAN_W:0] ext_s   = {1'b0, s2_sman};
  wire [MAN_W:0] raw_sum = same_sg ? ext_b + ext_s :
                           big_ge  ? ext_b - ext_s : ext_s - ext_b;
  wire           raw_sg  = (same_sg || big_ge) ? s2_bsg : s2_ssg;

  logic             s3_v, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [MAN_W:0]   s3_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s3_v <= 1'b0;
    else if (advance) s3_v <= s2_v;

  always_ff @(posedge clk)
    if (advance) begin
      s3_exp  <= s2_exp;
      s3_sign <= raw_sg;
      s3_sum  <= raw_sum;
    end

  // segment 4: normalize
  wire             carry   = s3_sum[MAN_W];
  wire             is_zero = s3_sum == '0;
  wire [SH_W-1:0]  lz      = lead_zeros(s3_sum[MAN_W-1:0]);
  wire             ovf     = carry && (s3_exp == EXP_MAX);
  wire             unf     = !carry && !is_zero && (EXP_W'(lz) >= s3_exp);
  wire [MAN_W-1:0] n_man   = carry ? s3_sum[MAN_W:1] : s3_sum[MAN_W-1:0] << lz;
  wire [EXP_W-1:0] n_exp   = is_zero ? '0 :
                             carry   ? (ovf ? EXP_MAX : s3_exp + 1'b1) :
                             unf     ? '0 : s3_exp - EXP_W'(lz);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else if (advance) out_valid <= s3_v;

  always_ff @(posedge clk)
    if (advance) begin
      out_sign  <= !is_zero && s3_sign;
      out_exp   <= n_exp;
      out_man   <= n_man;
      out_range <= ovf || unf;
    end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable({out_valid, out_sign, out_exp, out_man, out_range}));

  // R8
  valid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s3_v) |=> out_valid);

  // R6
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man == '0) |-> (out_exp == '0 && !out_sign && !out_range));

  // R5
  norm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man != '0) |-> out_man[MAN_W-1]);

  // R7
  range_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_range) |-> (out_exp == EXP_MAX || out_exp == '0));

endmodule

// File: tb/sim_fp_pipe_adder.sv
module sim_fp_pipe_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, stall, in_valid, in_ready, op_sub;
  logic a_sign, b_sign, out_valid, out_sign, out_range;
  logic [7:0] a_exp, b_exp, out_exp;
  logic [15:0] a_man, b_man, out_man;

  fp_pipe_adder #(.EXP_W(8), .MAN_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man), .out_valid(out_valid),
    .out_sign(out_sign), .out_exp(out_exp), .out_man(out_man), .out_range(out_range));

  // {op, as, ae, am, bs, be, bm, exp_sign, exp_exp, exp_man, exp_range}
  localparam int NV = 13;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd3,   16'h8000, 1'b0, 8'd3,   16'h8000, 1'b0, 8'd4,   16'h8000, 1'b0},
    {1'b0, 1'b0, 8'd5,   16'hC000, 1'b0, 8'd3,   16'h8000, 1'b0, 8'd5,   16'hE000, 1'b0},
    {1'b1, 1'b0, 8'd5,   16'hC000, 1'b0, 8'd5,   16'h8000, 1'b0, 8'd4,   16'h8000, 1'b0},
    {1'b0, 1'b0, 8'd5,   16'h8000, 1'b1, 8'd5,   16'hC000, 1'b1, 8'd4,   16'h8000, 1'b0},
    {1'b1, 1'b1, 8'd7,   16'hA000, 1'b1, 8'd7,   16'hA000, 1'b0, 8'd0,   16'h0000, 1'b0},
    {1'b0, 1'b0, 8'd40,  16'h8000, 1'b0, 8'd20,  16'hFFFF, 1'b0, 8'd40,  16'h8000, 1'b0},
    {1'b0, 1'b0, 8'd30,  16'h8000, 1'b0, 8'd15,  16'h8000, 1'b0, 8'd30,  16'h8001, 1'b0},
    {1'b0, 1'b0, 8'd255, 16'h8000, 1'b0, 8'd255, 16'h8000, 1'b0, 8'd255, 16'h8000, 1'b1},
    {1'b1, 1'b0, 8'd1,   16'h8000, 1'b0, 8'd1,   16'hC000, 1'b1, 8'd0,   16'h8000, 1'b1},
    {1'b1, 1'b0, 8'd20,  16'h8001, 1'b0, 8'd20,  16'h8000, 1'b0, 8'd5,   16'h8000, 1'b0},
    {1'b0, 1'b1, 8'd3,   16'h8000, 1'b0, 8'd6,   16'hA000, 1'b0, 8'd6,   16'h9000, 1'b0},
    {1'b1, 1'b0, 8'd4,   16'h8000, 1'b1, 8'd4,   16'h8000, 1'b0, 8'd5,   16'h8000, 1'b0},
    {1'b0, 1'b0, 8'd10,  16'h8000, 1'b0, 8'd9,   16'h8001, 1'b0, 8'd10,  16'hC000, 1'b0}
  };
  string tags [NV] = '{"R4", "R1", "R3", "R3", "R6", "R2", "R2", "R7", "R7", "R5", "R1", "R3", "R2"};

  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  task automatic drive(input logic [76:0] v, input logic vld);
    in_valid = vld; op_sub = v[76];
    a_sign = v[75]; a_exp = v[74:67]; a_man = v[66:51];
    b_sign = v[50]; b_exp = v[49:42]; b_man = v[41:26];
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_res(input logic [76:0] v, input string tag);
    chk(32'(out_valid), 32'd1, tag, "out_valid");
    chk(32'(out_sign), 32'(v[25]), tag, "sign");
    chk(32'(out_exp), 32'(v[24:17]), tag, "exponent");
    chk(32'(out_man), 32'(v[16:1]), tag, "mantissa");
    chk(32'(out_range), 32'(v[0]), tag, "range flag");
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    chk(32'(out_valid), 32'd0, "R10", "out_valid in reset");
    chk(32'(in_ready), 32'd1, "R9", "in_ready idle");
    rst_n = 1'b1;
    @(negedge clk);

    // stream, one pair per cycle (R8 throughput)
    for (int j = 0; j < NV + 4; j++) begin
      if (j >= 4) chk_res(VEC[j-4], tags[j-4]);
      if (j < NV) drive(VEC[j], 1'b1); else drive('0, 1'b0);
      @(negedge clk);
    end

    // R8 latency of a lone operation
    drive(VEC[1], 1'b1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (k == 4) chk_res(VEC[1], "R8");
      else chk(32'(out_valid), 32'd0, "R8", "out_valid off-slot");
    end

    // R9 stall together with a new request
    drive(VEC[10], 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    stall = 1'b1;
    drive(VEC[0], 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(32'(in_ready), 32'd0, "R9", "in_ready in stall");
      chk(32'(out_valid), 32'd0, "R9", "no early result");
    end
    stall = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(32'(out_valid), 32'd0, "R9", "resume step");
    @(negedge clk);
    chk_res(VEC[10], "R9");
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_res(VEC[10], "R9");
    end
    stall = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(32'(out_valid), 32'd0, "R9", "stalled request ignored");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule